// File: doc/BRIEF.md
# Hexadecimal-Exponent Float to IEEE Double Converter

This block takes one 32-bit floating-point word in the old base-16 format found in mainframe data files and turns it into the bit pattern of an IEEE-754 double. The input word holds a sign, a 7-bit exponent stored with an offset of 64 that scales by powers of sixteen, and a 24-bit fraction. The fraction has an implied zero to the left of the radix point and need not be normalized, so its leading one can fall anywhere in its 24 bits.

The converter finds the leading one with a count over the six hex digits of the fraction. It shifts the fraction so that this one becomes the hidden bit of the double, and it recomputes the binary exponent. Every input pattern is an ordinary number, and every one of them lands exactly on a normal double or on a signed zero. Words arrive four bytes at a time with a strobe. A select input reverses the byte order before decoding, so that files written in either byte order can be read. The block is a two-stage pipeline that accepts a word on every cycle.

Top module: `hexfp_to_double`

## Requirements
- R1: With `swap_bytes` low, `in_byte0` carries the sign (bit 7) and the excess-64 exponent (bits 6:0), and `in_byte1`, `in_byte2`, `in_byte3` form the 24-bit fraction from most to least significant. With `swap_bytes` high, the roles run in reverse: `in_byte3` is the sign/exponent byte and `in_byte0` is the least significant fraction byte.
- R2: Bit 63 of `out_dbl` equals the input sign bit for every input, zero fraction included.
- R3: For a nonzero fraction F and exponent E, `out_dbl` is the exact double of (-1)^sign × F × 2^(4·(E−64)−24).
- R4: A zero fraction yields a signed zero: bits 62:0 of `out_dbl` are all zero, whatever the exponent.
- R5: For a nonzero fraction whose leading one sits at bit p (0..23), the 11-bit double exponent field (bits 62:52) equals 4·E + p + 743. It therefore always lies between 743 and 1274.
- R6: The fraction bits below the leading one are placed directly under the hidden bit in bits 51:29 of `out_dbl`. Bits 28:0 are always zero.
- R7: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high, with the matching result on `out_dbl` in that same cycle. Back-to-back words are accepted on every cycle.
- R8: In a cycle where synchronous active-low reset `rst_n` is low, `out_valid` and `out_dbl` are cleared to zero on the next edge.
- R9: `out_dbl` keeps its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| swap_bytes | input | 1 | Reverse the order of the four input bytes before decoding |
| in_byte0 | input | 8 | Input byte 0 |
| in_byte1 | input | 8 | Input byte 1 |
| in_byte2 | input | 8 | Input byte 2 |
| in_byte3 | input | 8 | Input byte 3 |
| out_valid | output | 1 | Result present this cycle |
| out_dbl | output | 64 | IEEE-754 double-precision bit pattern |

## Verification
Two things can happen in the same cycle. The second stage renormalizes one word and writes it to the output while the first stage unpacks the next word under a different byte-order select. The bench therefore streams words back to back with `swap_bytes` toggling on every word. It sweeps every exponent against every leading-one position, and each result is judged against the exact double the bench computes as real arithmetic. Idle gaps in the stream show whether the output holds its value and whether the valid flag keeps the two-cycle spacing.

// File: rtl/hfd_pkg.sv
// Package: shared widths and the unpacked-field type for the
// hexadecimal-exponent to double converter. It assumes a 32-bit input word.
package hfd_pkg;
    localparam int EXP_W    = 7;            // input exponent width
    localparam int FRAC_W   = 24;           // input fraction width
    localparam int EXP_OFS  = 64;           // input exponent offset
    localparam int DIG_N    = FRAC_W / 4;   // hex digits in fraction
    localparam int LZ_W     = 5;            // width of a 0..24 count
    localparam int DEXP_W   = 11;           // double exponent width
    localparam int DFRAC_W  = 52;           // double fraction width
    localparam int DBIAS    = 1023;         // double exponent bias
    localparam int DBL_W    = 1 + DEXP_W + DFRAC_W;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } hfd_fields_t;
endpackage

// File: rtl/hfd_byte_order.sv
// Module: selects the byte order and splits the word into sign, exponent and
// fraction. Purely combinational. It assumes four bytes, of which the byte
// named first holds the sign and exponent unless swap is set.
module hfd_byte_order
    import hfd_pkg::*;
(
    input  logic        swap,
    input  logic [7:0]  b0,
    input  logic [7:0]  b1,
    input  logic [7:0]  b2,
    input  logic [7:0]  b3,
    output hfd_fields_t fields
);
    logic [31:0] word;

    // Concatenate the bytes in the chosen order, then split the fields.
    always_comb begin
        if (swap) word = {b3, b2, b1, b0};
        else      word = {b0, b1, b2, b3};
        fields.sign = word[31];
        fields.expo = word[30:24];
        fields.frac = word[FRAC_W-1:0];
    end
endmodule

// File: rtl/hfd_lzc.sv
// Module: leading-zero count over the fraction, organised per hex digit.
// Each digit reports a local count; the first nonzero digit from the top
// selects the result. A zero input reports zero_in = 1 and count FRAC_W.
// It assumes FRAC_W is a multiple of four.
module hfd_lzc
    import hfd_pkg::*;
(
    input  logic [FRAC_W-1:0] val,
    output logic [LZ_W-1:0]   lz,
    output logic              zero_in
);
    logic [DIG_N-1:0] dig_nz;
    logic [1:0]       dig_lz [DIG_N];

    // Per-digit detector: nonzero flag and count of zeros within the digit.
    for (genvar g = 0; g < DIG_N; g++) begin : g_digit
        logic [3:0] nib;
        assign nib = val[FRAC_W-1-4*g -: 4];
        assign dig_nz[g] = |nib;
        always_comb begin
            if      (nib[3]) dig_lz[g] = 2'd0;
            else if (nib[2]) dig_lz[g] = 2'd1;
            else if (nib[1]) dig_lz[g] = 2'd2;
            else             dig_lz[g] = 2'd3;
        end
    end

    // Priority across digits: the most significant nonzero digit wins.
    always_comb begin
        lz      = LZ_W'(FRAC_W);
        zero_in = 1'b1;
        for (int d = DIG_N - 1; d >= 0; d--) begin
            if (dig_nz[d]) begin
                lz      = LZ_W'(4 * d) + LZ_W'(dig_lz[d]);
                zero_in = 1'b0;
            end
        end
    end
endmodule

// File: rtl/hfd_pack.sv
// Module: renormalises the fraction to a hidden-one significand and builds
// the double bit pattern. Purely combinational. It assumes the leading-zero
// count comes from hfd_lzc and that every nonzero input maps to a normal double.
module hfd_pack
    import hfd_pkg::*;
(
    input  hfd_fields_t       fields,
    input  logic [LZ_W-1:0]   lz,
    input  logic              zero_in,
    output logic [DBL_W-1:0]  dbl
);
    localparam int PAD_W  = DFRAC_W - (FRAC_W - 1);
    localparam int EXP_K  = DBIAS - 4 * EXP_OFS - 1;   // 766 for defaults
    localparam int SUM_W  = DEXP_W + 2;

    logic [FRAC_W-1:0]  norm;
    logic [SUM_W-1:0]   dexp;
    logic [DFRAC_W-1:0] dfrac;

    // Shift the leading one to the top and form the binary exponent.
    always_comb begin
        norm  = fields.frac << lz;
        dexp  = SUM_W'(EXP_K) + (SUM_W'(fields.expo) << 2) - SUM_W'(lz);
        dfrac = {norm[FRAC_W-2:0], {PAD_W{1'b0}}};
    end

    // Assemble the output; a zero fraction gives a signed zero.
    always_comb begin
        if (zero_in) dbl = {fields.sign, {(DBL_W-1){1'b0}}};
        else         dbl = {fields.sign, dexp[DEXP_W-1:0], dfrac};
    end
endmodule

// File: rtl/hexfp_to_double.sv
// Module: top of the converter. Stage A registers the byte-ordered fields.
// Stage B counts leading zeros, packs the result and registers the output.
// Latency is two cycles with one word accepted per cycle. The output holds
// between results. It assumes a synchronous active-low reset.
module hexfp_to_double
    import hfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        swap_bytes,
    input  logic [7:0]  in_byte0,
    input  logic [7:0]  in_byte1,
    input  logic [7:0]  in_byte2,
    input  logic [7:0]  in_byte3,
    output logic        out_valid,
    output logic [63:0] out_dbl
);
    hfd_fields_t      fld_c, fld_a;
    logic             vld_a;
    logic [LZ_W-1:0]  lz_b;
    logic             zero_b;
    logic [DBL_W-1:0] dbl_b;

    hfd_byte_order u_order (
        .swap   (swap_bytes),
        .b0     (in_byte0),
        .b1     (in_byte1),
        .b2     (in_byte2),
        .b3     (in_byte3),
        .fields (fld_c)
    );

    // Stage A: capture the unpacked fields of an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_a <= 1'b0;
            fld_a <= '0;
        end else begin
            vld_a <= in_valid;
            if (in_valid) fld_a <= fld_c;
        end
    end

    hfd_lzc u_lzc (
        .val     (fld_a.frac),
        .lz      (lz_b),
        .zero_in (zero_b)
    );

    hfd_pack u_pack (
        .fields  (fld_a),
        .lz      (lz_b),
        .zero_in (zero_b),
        .dbl     (dbl_b)
    );

    // Stage B: register the packed double; hold it when nothing arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dbl   <= '0;
        end else begin
            out_valid <= vld_a;
            if (vld_a) out_dbl <= dbl_b;
        end
    end

    AST_VALID_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##2 out_valid); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> ##2 !out_valid); // R7
    AST_SIGN_CARRIED: assert property (@(posedge clk) disable iff (!rst_n) vld_a |=> out_dbl[63] == $past(fld_a.sign)); // R2
    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_dbl[62:52] == 11'd0) |-> out_dbl[51:0] == 52'd0); // R4
    AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_dbl[62:52] != 11'd0) |-> (out_dbl[62:52] >= 11'd743 && out_dbl[62:52] <= 11'd1274)); // R5
    AST_LOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_dbl[28:0] == 29'd0); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !vld_a |=> $stable(out_dbl)); // R9
endmodule

// File: tb/tb_hexfp_to_double.sv
// Bench: streams every exponent against every leading-one position, with both
// signs and both byte orders, plus signed zeros and idle gaps. Expected
// doubles come from real arithmetic.
module tb_hexfp_to_double;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        swap_bytes = 1'b0;
    logic [7:0]  in_byte0 = '0, in_byte1 = '0, in_byte2 = '0, in_byte3 = '0;
    logic        out_valid;
    logic [63:0] out_dbl;

    always #5 clk = ~clk;

    hexfp_to_double dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .swap_bytes(swap_bytes),
        .in_byte0(in_byte0), .in_byte1(in_byte1), .in_byte2(in_byte2),
        .in_byte3(in_byte3), .out_valid(out_valid), .out_dbl(out_dbl)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [63:0] exp_mem [0:8191];
    int          wr = 0, rd = 0;
    bit          v_d1 = 0, v_d2 = 0;
    logic [63:0] last_dbl = '0;

    // Exact expected double from the arithmetic meaning of the word (R3).
    function automatic logic [63:0] ref_dbl(bit s, int e, int f);
        real mag;
        if (f == 0) return {s, 63'd0};                       // R4
        mag = real'(f) * (2.0 ** (4 * (e - 64) - 24));
        return $realtobits(s ? -mag : mag);
    endfunction

    // Compare the outputs from the last edge, then drive the next input.
    task automatic step(bit v, bit s, int e, int f, bit sw);
        logic [7:0] hi;
        @(negedge clk);
        n_vec++;
        if (out_valid !== v_d2) begin
            n_bad++;
            $display("FAIL R7 out_valid act=%0b exp=%0b", out_valid, v_d2);
        end else if (v_d2) begin
            if (out_dbl !== exp_mem[rd]) begin
                n_bad++;
                $display("FAIL R1/R2/R3/R5/R6 out_dbl act=%h exp=%h", out_dbl, exp_mem[rd]);
            end
            rd++;
            last_dbl = out_dbl;
        end else if (out_dbl !== last_dbl) begin
            n_bad++;
            $display("FAIL R9 hold act=%h exp=%h", out_dbl, last_dbl);
        end
        v_d2 = v_d1;
        v_d1 = v;
        in_valid   = v;
        swap_bytes = sw;
        hi = {s, 7'(e)};
        if (sw) {in_byte3, in_byte2, in_byte1, in_byte0} = {hi, 24'(f)};
        else    {in_byte0, in_byte1, in_byte2, in_byte3} = {hi, 24'(f)};
        if (v) begin
            exp_mem[wr] = ref_dbl(s, e, f);
            wr++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        n_vec++;
        if (out_valid !== 1'b0 || out_dbl !== 64'd0) begin
            n_bad++;
            $display("FAIL R8 reset act=%0b/%h exp=0/0", out_valid, out_dbl);
        end
        rst_n = 1'b1;
        // R1 R3 R5 R6: every exponent against every leading-one position
        for (int e = 0; e < 128; e++) begin
            for (int p = 0; p < 24; p++) begin
                int f;
                f = (1 << p) | ((32'h5A3C96 ^ (e * 977)) & ((1 << p) - 1));
                step(1'b1, 1'((e + p) & 1), e, f, 1'(p & 1));
                if ((e * 24 + p) % 11 == 0) step(1'b0, 1'b0, 0, 0, 1'b0);   // R9 gap
            end
        end
        // R2 R4: signed zeros at several exponents, both byte orders
        for (int e = 0; e < 128; e += 9) begin
            step(1'b1, 1'b1, e, 0, 1'b0);
            step(1'b1, 1'b0, e, 0, 1'b1);
        end
        // Leading hex digits 1, 2, 4, 8 at the extreme exponents (R3 R5)
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 0,   (1 << k) << 20, 1'b0);
            step(1'b1, 1'b1, 127, ((1 << k) << 20) | 24'h0FFFFF, 1'b1);
            step(1'b1, 1'b1, 0,   ((1 << k) << 20) | 24'h012345, 1'b0);
            step(1'b1, 1'b0, 127, (1 << k) << 20, 1'b1);
        end
        // Drain the pipeline with idle cycles (R7 R9)
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, 1'b0);
        // R8: reset in mid-run clears the output
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_dbl !== 64'd0) begin
            n_bad++;
            $display("FAIL R8 re-reset act=%0b/%h exp=0/0", out_valid, out_dbl);
        end
        if (rd != wr) begin
            n_bad++;
            $display("FAIL R7 result count act=%0d exp=%0d", rd, wr);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule